// File: doc/BRIEF.md
# Keyed Index/Data Configuration Register File

This block is the configuration register space of a multi-function I/O device, reached through two byte-wide I/O addresses. One address acts as an index port and the other as a data port. A write to the index port picks an internal register, and data-port accesses then read or write that register. The block decodes the full I/O address itself. Addresses that match neither port are ignored.

Out of reset the space is sealed. It opens only after a fixed four-byte unlock key (0x87, 0x01, 0x55, 0x55) has been written to the index port in that order. It seals again when the exit command is written through the data port. While the space is open, a logical-device selector picks one of several register banks. Each bank holds an enable bit and a 16-bit base address. Bank state is also driven out on parallel outputs, so the device functions can use it directly. Identification and revision bytes for the whole device are read-only.

Top module: `cfg_port_regfile`

## Requirements
- R1: Reset, synchronous and active high, seals the space and clears the index, the device selector, every bank's enable and base address, and `bus_rdata` to 0x00.
- R2: The space opens only on the clock edge that accepts the fourth key byte. Index-port writes are the only thing that moves the key matcher. Data-port traffic while sealed leaves the matcher and the sealed state untouched.
- R3: An index-port write that is not the next expected key byte restarts the matching. If that byte is 0x87, it counts as the first key byte, so 87 01 87 01 55 55 and 87 01 55 87 01 55 55 both open the space.
- R4: While sealed, a read of either port returns 0xFF, data-port writes have no effect, and index-port writes do not change the index.
- R5: While open, writing 0x02 through the data port with index 0x02 selected seals the space on that edge. Any other value written at index 0x02 leaves the space open.
- R6: While open, an index-port write latches the byte as the index, and an index-port read returns it.
- R7: Index 0x20 reads the high byte of the CHIP_ID parameter and 0x21 its low byte. Index 0x22 reads CHIP_REV in bits 3:0 with bits 7:4 zero. Writes to these three indices have no effect.
- R8: Index 0x07 is the device selector, readable and writable as a full byte. Indices 0x30, 0x60 and 0x61 access the bank chosen by its current value.
- R9: Index 0x30 is the enable register. Bit 0 of a write is stored and reads back as {7'b0, enable}. Bit n of `dev_active` follows the enable of device n.
- R10: Index 0x60 holds the high byte and 0x61 the low byte of the 16-bit base address. Device n's base appears on `dev_base[16n+15:16n]`.
- R11: A read of an unimplemented index returns 0x00, and a write to one has no effect. A selector value of NUM_DEV or above reads 0x00 at every banked index and ignores writes there.
- R12: `bus_rdata` is registered. It changes only on the edge that samples `bus_rd` at one of the two ports, carrying the value from before any write on that edge. It holds its value at all other times, including accesses to other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | High while the register space is unlocked |
| dev_active | output | NUM_DEV | Enable bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device, device 0 in the low bits |

## Verification
The bench builds the block with NUM_DEV = 4, CHIP_ID = 0xA5C3 and CHIP_REV = 0x9. The asymmetric identification bytes show at once if the high and low halves are swapped. A non-zero revision exposes any leak into the upper nibble. With only four banks, selector values 4 and 9 fall outside the implemented range, so the out-of-range read and write-drop path can be reached in a short run. The behavioural reference model follows all four banks on every clock. The key-restart corner cases are driven as explicit byte streams.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int KEY_LEN = 4;
  // unlock key in the order it must be written, entry 0 first
  localparam logic [KEY_LEN-1:0][7:0] UNLOCK_KEY = {8'h55, 8'h55, 8'h01, 8'h87};

  localparam logic [7:0] IX_EXIT  = 8'h02;
  localparam logic [7:0] EXIT_CMD = 8'h02;
  localparam logic [7:0] IX_LDN   = 8'h07;
  localparam logic [7:0] IX_IDHI  = 8'h20;
  localparam logic [7:0] IX_IDLO  = 8'h21;
  localparam logic [7:0] IX_REV   = 8'h22;
  localparam logic [7:0] IX_ACT   = 8'h30;
  localparam logic [7:0] IX_BHI   = 8'h60;
  localparam logic [7:0] IX_BLO   = 8'h61;
  localparam logic [7:0] SEALED_RD = 8'hFF;
endpackage

// File: rtl/cfgp_key_detect.sv
module cfgp_key_detect
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       exit_req,
  output logic       unlocked
);
  localparam int PW = $clog2(KEY_LEN);
  localparam logic [PW-1:0] LAST = PW'(KEY_LEN - 1);

  logic [PW-1:0] pos_q;
  logic          open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      open_q <= 1'b0;
    end else if (open_q) begin
      pos_q <= '0;
      if (exit_req) open_q <= 1'b0;
    end else if (idx_wr) begin
      if (wdata == UNLOCK_KEY[pos_q]) begin
        if (pos_q == LAST) begin
          open_q <= 1'b1;
          pos_q  <= '0;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end else if (wdata == UNLOCK_KEY[0]) begin
        pos_q <= PW'(1);
      end else begin
        pos_q <= '0;
      end
    end
  end

  assign unlocked = open_q;

  AST_OPEN_AFTER_LAST_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> ($past(pos_q) == LAST && $past(idx_wr))); // R2
  AST_SEAL_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!idx_wr && !exit_req) |=> $stable(open_q)); // R2
  AST_POS_IDLE_OPEN: assert property (@(posedge clk) disable iff (rst)
    open_q |=> (pos_q == '0)); // R3
endmodule

// File: rtl/cfgp_bank_regs.sv
module cfgp_bank_regs #(
  parameter int NUM_DEV = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           sel_dev,
  input  logic                 wr_act,
  input  logic                 wr_bhi,
  input  logic                 wr_blo,
  input  logic [7:0]           wdata,
  output logic [7:0]           rd_act,
  output logic [7:0]           rd_bhi,
  output logic [7:0]           rd_blo,
  output logic [NUM_DEV-1:0]   dev_active,
  output logic [16*NUM_DEV-1:0] dev_base
);
  localparam int DW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic          dev_hit;
  logic [DW-1:0] sel;
  logic [NUM_DEV-1:0]       act_q;
  logic [NUM_DEV-1:0][15:0] base_q;

  assign dev_hit = ({1'b0, sel_dev} < 9'(NUM_DEV));
  assign sel     = sel_dev[DW-1:0];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic        act_r;
    logic [15:0] base_r;
    logic        mine;
    assign mine = dev_hit && (sel == DW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        act_r  <= 1'b0;
        base_r <= '0;
      end else if (mine) begin
        if (wr_act) act_r        <= wdata[0];
        if (wr_bhi) base_r[15:8] <= wdata;
        if (wr_blo) base_r[7:0]  <= wdata;
      end
    end
    assign act_q[g]  = act_r;
    assign base_q[g] = base_r;
    assign dev_base[16*g +: 16] = base_r;
  end

  assign dev_active = act_q;

  always_comb begin
    rd_act = 8'h00;
    rd_bhi = 8'h00;
    rd_blo = 8'h00;
    if (dev_hit) begin
      rd_act = {7'b0, act_q[sel]};
      rd_bhi = base_q[sel][15:8];
      rd_blo = base_q[sel][7:0];
    end
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_act |=> $stable(dev_active)); // R9
  AST_NO_GHOST_WRITE: assert property (@(posedge clk) disable iff (rst)
    !dev_hit |=> ($stable(dev_base) && $stable(dev_active))); // R11
  AST_ONE_BANK_MOVES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(dev_active ^ $past(dev_active)) <= 1); // R8
endmodule

// File: rtl/cfg_port_regfile.sv
module cfg_port_regfile
  import cfgp_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 'h2E,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h2F,
  parameter int              NUM_DEV  = 16,
  parameter logic [15:0]     CHIP_ID  = 16'h1234,
  parameter logic [3:0]      CHIP_REV = 4'h1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic                  cfg_open,
  output logic [NUM_DEV-1:0]    dev_active,
  output logic [16*NUM_DEV-1:0] dev_base
);
  logic idx_hit, dat_hit, idx_wr, dat_wr, rd_hit, exit_req, unlocked;
  logic [7:0] index_q, ldn_q, rd_val, rd_reg;
  logic [7:0] b_act, b_bhi, b_blo;
  logic [7:0] rdata_q;

  assign idx_hit  = (bus_addr == IDX_PORT);
  assign dat_hit  = (bus_addr == DAT_PORT);
  assign idx_wr   = bus_wr && idx_hit;
  assign dat_wr   = bus_wr && dat_hit && unlocked;
  assign rd_hit   = bus_rd && (idx_hit || dat_hit);
  assign exit_req = dat_wr && (index_q == IX_EXIT) && (bus_wdata == EXIT_CMD);

  cfgp_key_detect u_key (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .wdata    (bus_wdata),
    .exit_req (exit_req),
    .unlocked (unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (idx_wr && unlocked) index_q <= bus_wdata;
      if (dat_wr && index_q == IX_LDN) ldn_q <= bus_wdata;
    end
  end

  cfgp_bank_regs #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .sel_dev    (ldn_q),
    .wr_act     (dat_wr && index_q == IX_ACT),
    .wr_bhi     (dat_wr && index_q == IX_BHI),
    .wr_blo     (dat_wr && index_q == IX_BLO),
    .wdata      (bus_wdata),
    .rd_act     (b_act),
    .rd_bhi     (b_bhi),
    .rd_blo     (b_blo),
    .dev_active (dev_active),
    .dev_base   (dev_base)
  );

  always_comb begin
    unique case (index_q)
      IX_LDN:  rd_reg = ldn_q;
      IX_IDHI: rd_reg = CHIP_ID[15:8];
      IX_IDLO: rd_reg = CHIP_ID[7:0];
      IX_REV:  rd_reg = {4'h0, CHIP_REV};
      IX_ACT:  rd_reg = b_act;
      IX_BHI:  rd_reg = b_bhi;
      IX_BLO:  rd_reg = b_blo;
      default: rd_reg = 8'h00;
    endcase
    if (!unlocked)    rd_val = SEALED_RD;
    else if (idx_hit) rd_val = index_q;
    else              rd_val = rd_reg;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign cfg_open  = unlocked;

  AST_SEALED_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !cfg_open) |=> (bus_rdata == 8'hFF)); // R4
  AST_EXIT_SEALS: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && bus_wr && dat_hit && index_q == IX_EXIT && bus_wdata == EXIT_CMD) |=> !cfg_open); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(bus_rdata)); // R12
  AST_SEALED_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(index_q)); // R4
endmodule

// File: tb/sim_cfg_port_regfile.sv
`timescale 1ns/100ps
module sim_cfg_port_regfile;
  localparam int ND = 4;
  localparam logic [15:0] ID = 16'hA5C3;
  localparam logic [3:0]  RV = 4'h9;
  localparam logic [15:0] PI = 16'h002E;
  localparam logic [15:0] PD = 16'h002F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic cfg_open;
  logic [ND-1:0] dev_active;
  logic [16*ND-1:0] dev_base;

  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_port_regfile #(.NUM_DEV(ND), .CHIP_ID(ID), .CHIP_REV(RV)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open),
    .dev_active(dev_active), .dev_base(dev_base));

  // behavioural reference model
  int m_open, m_pos, m_idx, m_ldn, m_rd;
  int m_act[ND];
  int m_base[ND];
  int key[4] = '{8'h87, 8'h01, 8'h55, 8'h55};
  bit started = 0;

  function automatic int model_read(bit at_index);
    if (!m_open) return 8'hFF;
    if (at_index) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return int'(ID[15:8]);
      8'h21: return int'(ID[7:0]);
      8'h22: return int'(RV);
      8'h30: return (m_ldn < ND) ? m_act[m_ldn] : 0;
      8'h60: return (m_ldn < ND) ? (m_base[m_ldn] >> 8) : 0;
      8'h61: return (m_ldn < ND) ? (m_base[m_ldn] & 8'hFF) : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_open = 0; m_pos = 0; m_idx = 0; m_ldn = 0; m_rd = 0;
      foreach (m_act[i]) begin m_act[i] = 0; m_base[i] = 0; end
    end else begin
      int wd;
      wd = int'(bus_wdata);
      if (bus_rd && (bus_addr == PI || bus_addr == PD)) m_rd = model_read(bus_addr == PI);
      if (bus_wr && bus_addr == PI) begin
        if (m_open) m_idx = wd;
        else if (wd == key[m_pos]) begin
          if (m_pos == 3) begin m_open = 1; m_pos = 0; end
          else m_pos++;
        end else m_pos = (wd == 8'h87) ? 1 : 0;
      end else if (bus_wr && bus_addr == PD && m_open) begin
        if (m_idx == 8'h02 && wd == 8'h02) m_open = 0;
        else if (m_idx == 8'h07) m_ldn = wd;
        else if (m_ldn < ND) begin
          if (m_idx == 8'h30) m_act[m_ldn] = wd & 1;
          if (m_idx == 8'h60) m_base[m_ldn] = (m_base[m_ldn] & 8'hFF) | (wd << 8);
          if (m_idx == 8'h61) m_base[m_ldn] = (m_base[m_ldn] & 16'hFF00) | wd;
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      check("R2 cfg_open vs model", int'(cfg_open), m_open);
      check("R12 bus_rdata vs model", int'(bus_rdata), m_rd);
      for (int i = 0; i < ND; i++) begin
        check("R9 dev_active vs model", int'(dev_active[i]), m_act[i]);
        check("R10 dev_base vs model", int'(dev_base[16*i +: 16]), m_base[i]);
      end
    end
  end

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] ix, int exp, string tag);
    wr(PI, ix);
    rd(PD);
    check(tag, int'(bus_rdata), exp);
  endtask

  task automatic reg_wr(logic [7:0] ix, logic [7:0] d);
    wr(PI, ix);
    wr(PD, d);
  endtask

  task automatic send_key(int n, int b0, int b1, int b2, int b3, int b4, int b5, int b6);
    int s[7] = '{b0, b1, b2, b3, b4, b5, b6};
    for (int i = 0; i < n; i++) wr(PI, 8'(s[i]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rdata", int'(bus_rdata), 0);
    check("R1 reset sealed", int'(cfg_open), 0);
    check("R1 reset banks", int'(dev_active), 0);

    // sealed behaviour
    rd(PD); check("R4 sealed data read", int'(bus_rdata), 8'hFF);
    rd(PI); check("R4 sealed index read", int'(bus_rdata), 8'hFF);
    wr(PD, 8'h87); wr(PD, 8'h01);
    check("R2 data port no key", int'(cfg_open), 0);

    // broken key and restart cases
    send_key(4, 8'h87, 8'h01, 8'h55, 8'h00, 0, 0, 0);
    check("R3 wrong last byte", int'(cfg_open), 0);
    send_key(3, 8'h87, 8'h01, 8'h55, 0, 0, 0, 0);
    check("R2 three bytes stay sealed", int'(cfg_open), 0);
    wr(PI, 8'h55);
    check("R2 fourth byte opens", int'(cfg_open), 1);

    // identification
    wr(PI, 8'h20); rd(PI);
    check("R6 index readback", int'(bus_rdata), 8'h20);
    reg_rd(8'h20, 8'hA5, "R7 id high");
    reg_rd(8'h21, 8'hC3, "R7 id low");
    reg_rd(8'h22, 8'h09, "R7 revision");
    reg_wr(8'h20, 8'h77);
    reg_rd(8'h20, 8'hA5, "R7 id write ignored");

    // banks
    reg_wr(8'h07, 8'h02);
    reg_rd(8'h07, 8'h02, "R8 selector readback");
    reg_wr(8'h30, 8'hFF);
    reg_rd(8'h30, 8'h01, "R9 enable reads bit0");
    check("R9 dev_active", int'(dev_active), 4'b0100);
    reg_wr(8'h60, 8'h12);
    reg_wr(8'h61, 8'h34);
    reg_rd(8'h60, 8'h12, "R10 base high");
    reg_rd(8'h61, 8'h34, "R10 base low");
    check("R10 dev_base", int'(dev_base[47:32]), 16'h1234);
    reg_wr(8'h07, 8'h01);
    reg_rd(8'h30, 8'h00, "R8 other bank");
    reg_rd(8'h60, 8'h00, "R8 other bank base");
    reg_wr(8'h07, 8'h09);
    reg_wr(8'h30, 8'h01);
    reg_wr(8'h61, 8'hAB);
    reg_rd(8'h30, 8'h00, "R11 out of range enable");
    reg_rd(8'h61, 8'h00, "R11 out of range base");
    check("R11 no bank written", int'(dev_active), 4'b0100);
    reg_wr(8'h55, 8'h66);
    reg_rd(8'h55, 8'h00, "R11 unimplemented index");

    // foreign addresses
    reg_rd(8'h21, 8'hC3, "R12 prime");
    wr(16'h0080, 8'h02); rd(16'h0080);
    check("R12 foreign read holds", int'(bus_rdata), 8'hC3);

    // exit
    reg_wr(8'h02, 8'h05);
    check("R5 other value stays open", int'(cfg_open), 1);
    wr(PD, 8'h02);
    check("R5 exit seals", int'(cfg_open), 0);
    rd(PD); check("R4 sealed after exit", int'(bus_rdata), 8'hFF);

    send_key(6, 8'h87, 8'h01, 8'h87, 8'h01, 8'h55, 8'h55, 0);
    check("R3 restart at 0x87 (a)", int'(cfg_open), 1);
    reg_wr(8'h02, 8'h02);
    send_key(7, 8'h87, 8'h01, 8'h55, 8'h87, 8'h01, 8'h55, 8'h55);
    check("R3 restart at 0x87 (b)", int'(cfg_open), 1);
    rd(PI); check("R4 index kept while sealed", int'(bus_rdata), 8'h02);

    // reset while open
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 reset reseals", int'(cfg_open), 0);
    check("R1 reset clears base", int'(dev_base[47:32]), 0);
    send_key(4, 8'h87, 8'h01, 8'h55, 8'h55, 0, 0, 0);
    rd(PI); check("R1 reset clears index", int'(bus_rdata), 0);
    reg_rd(8'h07, 8'h00, "R1 reset clears selector");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule